// File: doc/BRIEF.md
# Split-Operand 32x32 Unsigned Multiplier

This block multiplies two unsigned 32-bit operands with no clock and returns the full 64-bit product. It never builds one flat partial-product array. Each operand is cut into an upper and a lower 16-bit half, and the four half-by-half products are formed independently. The block then adds them back together at their binary weights: the upper-by-upper product is shifted up by 32 bits, and the two mixed products are added to each other and shifted up by 16 bits.

Each 16x16 product is made the same way from four 8x8 products. Every 8x8 leaf works column by column. For each result column it counts the one-bit products whose indices sum to that column, adds the carry left over from the column below, keeps the low bit as the result bit, and passes the rest up. All recombination additions at both levels go through a block carry-lookahead adder.

The block sits in a datapath as purely combinational logic. Any register stage belongs to whatever surrounds it.

Top module: `split_mul32`

## Requirements
- R1: For every pair of unsigned 32-bit operands, `product` equals the exact 64-bit unsigned product of `opnd_a` and `opnd_b`.
- R2: When either operand is zero, `product` is zero.
- R3: 0xFFFFFFFF times 0xFFFFFFFF gives 0xFFFFFFFE00000001.
- R4: When bits [31:16] of both operands are zero, `product[63:32]` is zero and `product[31:0]` is the 16x16 product of the low halves.
- R5: When bits [15:0] of both operands are zero, `product[31:0]` is zero and `product[63:32]` is the 16x16 product of the high halves.
- R6: When one operand has only its high half non-zero and the other has only its low half non-zero, `product` is their half product shifted left by 16, with bits [15:0] and [63:48] zero.
- R7: The sum of the two mixed half products is kept to 33 bits. When that sum overflows 32 bits, the carry appears at product bit 48.
- R8: Column carries inside an 8x8 leaf propagate correctly. For example, 0xFF times 0xFF gives 0xFE01, and 0xFFFF times 0xFFFF gives 0xFFFE0001.
- R9: The block holds no state. `product` follows any change of the operands within the same time step, with no clock involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | Unsigned multiplicand |
| opnd_b | input | 32 | Unsigned multiplier |
| product | output | 64 | Full unsigned product |

## Verification
The hardest case to reach from the ports is a carry out of the 33-bit middle sum landing at bit 48. Operands must be chosen so that both mixed half products are large at the same time. The stimulus gets there with both upper halves and both lower halves near 0xFFFF, for example 0xFFFF_FFFF times 0xFFFF_FFFF and 0xFFFF_FFFE times 0xFFFF_FFFD. Each result is compared against a plain reference multiply. Operands that are non-zero in only one half isolate each cross product, so a misplaced shift shows up as non-zero bits in a field that must stay clear.

// File: rtl/split_mul_pkg.sv
package split_mul_pkg;
    // width of the column-wise leaf multiplier
    localparam int LEAF_W = 8;
    // bits per lookahead group in the recombination adders
    localparam int GRP_W  = 4;
endpackage

// File: rtl/smul_cla.sv
module smul_cla
    import split_mul_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] s
);
    localparam int NG = (W + GRP_W - 1) / GRP_W;

    logic [W-1:0]  gen_d;
    logic [W-1:0]  prop_d;
    logic [NG-1:0] grp_gen_d;
    logic [NG-1:0] grp_prop_d;

    assign gen_d  = x & y;
    assign prop_d = x ^ y;

    // group generate / propagate terms
    always_comb begin
        int idx;
        grp_gen_d  = '0;
        grp_prop_d = '0;
        for (int g = 0; g < NG; g++) begin
            grp_gen_d[g]  = 1'b0;
            grp_prop_d[g] = 1'b1;
            for (int k = 0; k < GRP_W; k++) begin
                idx = g * GRP_W + k;
                if (idx < W) begin
                    grp_gen_d[g]  = gen_d[idx] | (prop_d[idx] & grp_gen_d[g]);
                    grp_prop_d[g] = grp_prop_d[g] & prop_d[idx];
                end
            end
        end
    end

    // group carries skip across groups; bits inside a group take the group carry-in
    always_comb begin
        logic c_grp;
        logic c_bit;
        int   idx;
        s     = '0;
        c_grp = 1'b0;
        for (int g = 0; g < NG; g++) begin
            c_bit = c_grp;
            for (int k = 0; k < GRP_W; k++) begin
                idx = g * GRP_W + k;
                if (idx < W) begin
                    s[idx] = prop_d[idx] ^ c_bit;
                    c_bit  = gen_d[idx] | (prop_d[idx] & c_bit);
                end
            end
            c_grp = grp_gen_d[g] | (grp_prop_d[g] & c_grp);
        end
    end
endmodule

// File: rtl/smul_leaf.sv
module smul_leaf
    import split_mul_pkg::*;
#(
    parameter int W = LEAF_W
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);
    localparam int IW  = $clog2(W);
    localparam int ACW = $clog2(W) + 2;

    logic [2*W-1:0] prod_d;

    // column k sums every a[i]&b[k-i] plus the carry from column k-1
    always_comb begin
        logic [ACW-1:0] acc;
        acc    = '0;
        prod_d = '0;
        for (int k = 0; k < 2 * W - 1; k++) begin
            for (int i = 0; i < W; i++) begin
                if ((k - i >= 0) && (k - i < W)) begin
                    acc = acc + {{(ACW-1){1'b0}}, a[i] & b[IW'(k - i)]};
                end
            end
            prod_d[k] = acc[0];
            acc       = acc >> 1;
        end
        prod_d[2*W-1] = acc[0];
    end

    assign p = prod_d;
endmodule

// File: rtl/smul_combine.sv
module smul_combine #(
    parameter int H = 16
) (
    input  logic [2*H-1:0] lo_lo,
    input  logic [2*H-1:0] hi_lo,
    input  logic [2*H-1:0] lo_hi,
    input  logic [2*H-1:0] hi_hi,
    output logic [4*H-1:0] sum
);
    logic [2*H:0]   mid_q;
    logic [4*H-1:0] base_d;
    logic [4*H-1:0] mid_shift_d;

    // the two mixed products: 2H+1 bits so the carry survives
    smul_cla #(.W(2*H+1)) u_mid (
        .x ({1'b0, hi_lo}),
        .y ({1'b0, lo_hi}),
        .s (mid_q)
    );

    always_comb begin
        base_d      = {hi_hi, lo_lo};
        mid_shift_d = {{(H-1){1'b0}}, mid_q, {H{1'b0}}};
    end

    smul_cla #(.W(4*H)) u_final (
        .x (base_d),
        .y (mid_shift_d),
        .s (sum)
    );
endmodule

// File: rtl/smul_mid16.sv
module smul_mid16
    import split_mul_pkg::*;
#(
    parameter int W = 2 * LEAF_W
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);
    localparam int H = W / 2;

    logic [2*H-1:0] part_q [4];

    // index bit0 picks the half of a, bit1 the half of b
    for (genvar q = 0; q < 4; q++) begin : g_part
        smul_leaf #(.W(H)) u_leaf (
            .a (a[(q % 2) * H +: H]),
            .b (b[(q / 2) * H +: H]),
            .p (part_q[q])
        );
    end

    smul_combine #(.H(H)) u_comb (
        .lo_lo (part_q[0]),
        .hi_lo (part_q[1]),
        .lo_hi (part_q[2]),
        .hi_hi (part_q[3]),
        .sum   (p)
    );
endmodule

// File: rtl/split_mul32.sv
module split_mul32
    import split_mul_pkg::*;
#(
    parameter int W = 4 * LEAF_W
) (
    input  logic [W-1:0]   opnd_a,
    input  logic [W-1:0]   opnd_b,
    output logic [2*W-1:0] product
);
    localparam int H = W / 2;

    logic [2*H-1:0] half_q [4];

    for (genvar q = 0; q < 4; q++) begin : g_half
        smul_mid16 #(.W(H)) u_mid (
            .a (opnd_a[(q % 2) * H +: H]),
            .b (opnd_b[(q / 2) * H +: H]),
            .p (half_q[q])
        );
    end

    smul_combine #(.H(H)) u_comb (
        .lo_lo (half_q[0]),
        .hi_lo (half_q[1]),
        .lo_hi (half_q[2]),
        .hi_hi (half_q[3]),
        .sum   (product)
    );
endmodule

// File: rtl/split_mul32_chk.sv
module split_mul32_chk #(
    parameter int W = 32
) (
    input logic [W-1:0]   opnd_a,
    input logic [W-1:0]   opnd_b,
    input logic [2*W-1:0] product
);
    localparam int H = W / 2;

    logic [2*W-1:0] ref_d;
    logic [W-1:0]   lo_ref_d;

    always_comb begin
        ref_d    = (2*W)'(opnd_a) * (2*W)'(opnd_b);
        lo_ref_d = W'(opnd_a[H-1:0]) * W'(opnd_b[H-1:0]);
    end

    always_comb begin
        // R1
        full_product_chk: assert (product == ref_d);
        // R2
        zero_operand_chk: assert (!((opnd_a == '0) || (opnd_b == '0)) || (product == '0));
        // R4
        low_halves_chk: assert (!((opnd_a[W-1:H] == '0) && (opnd_b[W-1:H] == '0))
                                || ((product[2*W-1:W] == '0) && (product[W-1:0] == lo_ref_d)));
        // R5
        high_halves_chk: assert (!((opnd_a[H-1:0] == '0) && (opnd_b[H-1:0] == '0))
                                 || (product[W-1:0] == '0));
    end
endmodule

bind split_mul32 split_mul32_chk #(.W(W)) u_chk (
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .product (product)
);

// File: tb/sim_split_mul32.sv
module sim_split_mul32;
    localparam int CLK_PERIOD = 10;

    logic        clk;
    logic        rst;
    logic [31:0] a;
    logic [31:0] b;
    logic [63:0] p;
    int          n_checks;
    int          n_fail;
    bit          done;

    split_mul32 u0 (
        .opnd_a  (a),
        .opnd_b  (b),
        .product (p)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s a=%h b=%h actual=%h expected=%h", req, a, b, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] av, input logic [31:0] bv);
        @(negedge clk);
        a = av;
        b = bv;
        #1;
    endtask

    function automatic logic [63:0] ref_mul(input logic [31:0] x, input logic [31:0] y);
        return 64'(x) * 64'(y);
    endfunction

    task automatic t_reset_state;
        apply(32'h0, 32'h0);
        check("R2 reset", p, 64'h0);
    endtask

    task automatic t_zero;
        apply(32'h0, 32'hDEAD_BEEF);
        check("R2", p, 64'h0);
        apply(32'hFFFF_FFFF, 32'h0);
        check("R2", p, 64'h0);
    endtask

    task automatic t_all_ones;
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        check("R3", p, 64'hFFFF_FFFE_0000_0001);
    endtask

    task automatic t_low_only;
        apply(32'h0000_FFFF, 32'h0000_FFFF);
        check("R4 R8", p, 64'h0000_0000_FFFE_0001);
        apply(32'h0000_1234, 32'h0000_ABCD);
        check("R4", p, 64'h1234 * 64'hABCD);
    endtask

    task automatic t_high_only;
        apply(32'hFFFF_0000, 32'h8001_0000);
        check("R5", p, (64'hFFFF * 64'h8001) << 32);
        check("R5 low", {32'h0, p[31:0]}, 64'h0);
    endtask

    task automatic t_cross;
        apply(32'h1234_0000, 32'h0000_5678);
        check("R6", p, (64'h1234 * 64'h5678) << 16);
        apply(32'h0000_FFFF, 32'hFFFF_0000);
        check("R6", p, 64'h0000_FFFE_0001_0000);
    endtask

    task automatic t_mid_carry;
        apply(32'hFFFF_FFFE, 32'hFFFF_FFFD);
        check("R7", p, ref_mul(32'hFFFF_FFFE, 32'hFFFF_FFFD));
        apply(32'h8000_FFFF, 32'hFFFF_8000);
        check("R7", p, ref_mul(32'h8000_FFFF, 32'hFFFF_8000));
    endtask

    task automatic t_leaf_carry;
        apply(32'h0000_00FF, 32'h0000_00FF);
        check("R8", p, 64'hFE01);
        apply(32'h0000_00FF, 32'h0000_0001);
        check("R8", p, 64'hFF);
    endtask

    task automatic t_same_step;
        apply(32'h0000_0003, 32'h0000_0005);
        a = 32'h0000_0007;
        #0.1;
        check("R9", p, 64'd35);
    endtask

    task automatic t_random;
        for (int i = 0; i < 300; i++) begin
            logic [31:0] ra;
            logic [31:0] rb;
            ra = $urandom();
            rb = $urandom();
            apply(ra, rb);
            check("R1", p, ref_mul(ra, rb));
        end
    endtask

    initial begin
        n_checks = 0;
        n_fail   = 0;
        done     = 1'b0;
        a        = '0;
        b        = '0;
        rst      = 1'b1;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        t_reset_state();
        t_zero();
        t_all_ones();
        t_low_only();
        t_high_only();
        t_cross();
        t_mid_carry();
        t_leaf_carry();
        t_same_step();
        t_random();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule